// File: doc/BRIEF.md
# Oscillator Clock Divider and Start-up Gate

This block turns one free-running oscillator clock into the clock enables that the rest of a small processor subsystem runs on. All logic is synchronous to the oscillator clock. No derived clock net is created: the block produces a one-cycle CPU clock enable, a peripheral clock enable at half the CPU rate, and a clock-output level that a pad driver can send off chip.

After any reset, the start-up controller holds every enable low. It waits a number of oscillator cycles that depends on the kind of oscillator in use: crystal sources need a longer settling time than the on-chip RC or watchdog oscillators. The controller has two states. It stays in `ST_HOLD` while its cycle counter runs, and takes the single transition `ST_HOLD -> ST_RUN` when the counter reaches the limit chosen by the source code. It leaves `ST_RUN` only through reset, which always returns it to `ST_HOLD`. The `ready` output is high exactly in `ST_RUN`.

The CPU enable rate is the oscillator rate divided by twice an 8-bit ratio. A ratio of zero means no division. Software may write the ratio at any time. A new value waits in a holding register and is taken only when the running period ends, so no period is ever cut short. The clock-output enable bit lives in a flop that only the power-on reset clears. An ordinary reset leaves it as it was.

Top module: `osc_clk_ctrl`

## Requirements
- R1: With source code 2'b10 or 2'b11 (crystal types, code bit 1 set), `ready` rises after exactly 992 oscillator rising edges with both resets released.
- R2: With source code 2'b00 (RC) or 2'b01 (watchdog oscillator), `ready` rises after exactly 224 oscillator rising edges with both resets released.
- R3: While `ready` is low, `cpu_ce`, `per_ce` and `clk_out` are all low. Once high, `ready` stays high until the next reset.
- R4: The divider register resets to 0. With ratio 0, `cpu_ce` is high in every cycle while `ready` is high.
- R5: With ratio N from 1 to 255, `cpu_ce` is a single-cycle pulse repeating every 2N oscillator cycles. N=255 gives 510.
- R6: A ratio written in the middle of a period does not change that period. The next period uses the new ratio.
- R7: `per_ce` coincides with every second `cpu_ce`, starting with the first one after `ready` rises, so its period is 4N cycles (2 for N=0).
- R8: When the clock-output enable bit is 1, `clk_out` toggles on each `cpu_ce`, so its period is 4N cycles. When the bit is 0, `clk_out` is held low.
- R9: The clock-output enable bit resets to 0 only on `por_n`. A pulse on `rst_n` alone leaves it unchanged.
- R10: The first `cpu_ce` occurs in the first cycle in which `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Selected oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Any other reset or wakeup restart, active low, asynchronous |
| src_sel | input | 2 | Oscillator source code; bit 1 set means crystal; hold steady during start-up |
| div_we | input | 1 | Write strobe for the divider ratio |
| div_wdata | input | 8 | Divider ratio N |
| cko_we | input | 1 | Write strobe for the clock-output enable bit |
| cko_wdata | input | 1 | Value for the clock-output enable bit |
| cpu_ce | output | 1 | CPU clock enable, one cycle wide |
| per_ce | output | 1 | Peripheral clock enable, every second CPU enable |
| clk_out | output | 1 | Clock-output pin level |
| ready | output | 1 | Start-up delay has expired |

## Verification
The embedded assertions watch several things on every cycle: that no enable or output edge appears before `ready`, that `ready` never drops without a reset, that a nonzero ratio never yields back-to-back CPU enables while a zero ratio yields them continuously, that peripheral enables never come two in a row, and that `clk_out` moves only on a CPU enable and is low whenever the output bit is clear. Other behaviours need the bench's directed scenarios to show them. These are the exact start-up lengths for each source code, the cycle counts between enables for particular ratios, the fact that a ratio written mid-period waits for the period to finish, and whether the output enable bit survives an ordinary reset but not a power-on reset.

// File: rtl/osc_clk_pkg.sv
`timescale 1ns/1ps
package osc_clk_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } wake_state_t;

    localparam logic [1:0] SRC_RC      = 2'b00;
    localparam logic [1:0] SRC_WDOG    = 2'b01;
    localparam logic [1:0] SRC_XTAL    = 2'b10;
    localparam logic [1:0] SRC_XTAL_HI = 2'b11;

    function automatic logic src_is_crystal(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/wake_timer.sv
`timescale 1ns/1ps
module wake_timer
    import osc_clk_pkg::*;
#(
    parameter int HOLD_XTAL = 992,
    parameter int HOLD_INT  = 224
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    output logic       ready
);
    localparam int HOLD_MAX = (HOLD_XTAL > HOLD_INT) ? HOLD_XTAL : HOLD_INT;
    localparam int CW       = $clog2(HOLD_MAX + 1);
    localparam logic [CW-1:0] LIM_XTAL = CW'(HOLD_XTAL - 1);
    localparam logic [CW-1:0] LIM_INT  = CW'(HOLD_INT - 1);

    wake_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] limit;

    assign limit = src_is_crystal(src_sel) ? LIM_XTAL : LIM_INT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                if (cnt_q == limit) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        ready = (state_q == ST_RUN);
    end

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q <= LIM_XTAL || cnt_q <= LIM_INT));

endmodule

// File: rtl/ce_divider.sv
`timescale 1ns/1ps
module ce_divider #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          div_we,
    input  logic [DW-1:0] div_wdata,
    output logic          cpu_ce
);
    localparam int CNTW = DW + 1;

    logic [DW-1:0]   ratio_q;
    logic [CNTW-1:0] cnt_q;
    logic            term;

    assign term = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= '0;
        end else if (div_we) begin
            ratio_q <= div_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (term) begin
            if (ratio_q == '0) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= {ratio_q, 1'b0} - CNTW'(1);
            end
        end else if (run) begin
            cnt_q <= cnt_q - CNTW'(1);
        end
    end

    always_comb begin
        cpu_ce = term;
    end

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && ratio_q != '0) |=> !cpu_ce);

    p_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && ratio_q == '0) |=> cpu_ce);

    p_idle_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt_q == '0));

endmodule

// File: rtl/clk_fanout.sv
`timescale 1ns/1ps
module clk_fanout (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cpu_ce,
    input  logic cko_we,
    input  logic cko_wdata,
    output logic per_ce,
    output logic clk_out
);
    logic phase_q;
    logic cko_en_q;
    logic clk_out_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cko_en_q <= 1'b0;
        end else if (cko_we) begin
            cko_en_q <= cko_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= 1'b0;
            clk_out_q <= 1'b0;
        end else begin
            if (cpu_ce) begin
                phase_q <= ~phase_q;
            end
            if (!cko_en_q) begin
                clk_out_q <= 1'b0;
            end else if (cpu_ce) begin
                clk_out_q <= ~clk_out_q;
            end
        end
    end

    always_comb begin
        per_ce  = cpu_ce && !phase_q;
        clk_out = clk_out_q;
    end

    p_per_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        per_ce |=> !per_ce);

    p_cko_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cko_en_q |=> !clk_out);

    p_cko_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cko_en_q && !cpu_ce) |=> $stable(clk_out));

endmodule

// File: rtl/osc_clk_ctrl.sv
`timescale 1ns/1ps
module osc_clk_ctrl #(
    parameter int HOLD_XTAL = 992,
    parameter int HOLD_INT  = 224,
    parameter int DIV_W     = 8
) (
    input  logic             clk_osc,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             cko_we,
    input  logic             cko_wdata,
    output logic             cpu_ce,
    output logic             per_ce,
    output logic             clk_out,
    output logic             ready
);
    logic rst_all_n;
    logic run;

    assign rst_all_n = rst_n & por_n;

    wake_timer #(
        .HOLD_XTAL (HOLD_XTAL),
        .HOLD_INT  (HOLD_INT)
    ) u_wake (
        .clk     (clk_osc),
        .rst_n   (rst_all_n),
        .src_sel (src_sel),
        .ready   (run)
    );

    ce_divider #(
        .DW (DIV_W)
    ) u_div (
        .clk       (clk_osc),
        .rst_n     (rst_all_n),
        .run       (run),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .cpu_ce    (cpu_ce)
    );

    clk_fanout u_fan (
        .clk       (clk_osc),
        .por_n     (por_n),
        .rst_n     (rst_all_n),
        .cpu_ce    (cpu_ce),
        .cko_we    (cko_we),
        .cko_wdata (cko_wdata),
        .per_ce    (per_ce),
        .clk_out   (clk_out)
    );

    assign ready = run;

    p_gate_all_r3: assert property (@(posedge clk_osc) disable iff (!rst_all_n)
        !ready |-> (!cpu_ce && !per_ce && !clk_out));

    p_first_ce_r10: assert property (@(posedge clk_osc) disable iff (!rst_all_n)
        $rose(ready) |-> (cpu_ce && per_ce));

endmodule

// File: tb/test_osc_clk_ctrl.sv
`timescale 1ns/1ps
module test_osc_clk_ctrl;
    logic       clk_osc = 1'b0;
    logic       por_n, rst_n;
    logic [1:0] src_sel;
    logic       div_we;
    logic [7:0] div_wdata;
    logic       cko_we, cko_wdata;
    logic       cpu_ce, per_ce, clk_out, ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk_osc = ~clk_osc;

    osc_clk_ctrl i_osc_clk_ctrl (
        .clk_osc   (clk_osc),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .cko_we    (cko_we),
        .cko_wdata (cko_wdata),
        .cpu_ce    (cpu_ce),
        .per_ce    (per_ce),
        .clk_out   (clk_out),
        .ready     (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ce();
        int g = 0;
        do begin
            @(negedge clk_osc);
            g++;
        end while (!cpu_ce && g < 3000);
    endtask

    task automatic measure_ce(output int k);
        k = 0;
        do begin
            @(negedge clk_osc);
            k++;
        end while (!cpu_ce && k < 3000);
    endtask

    task automatic write_div(input logic [7:0] n);
        @(negedge clk_osc);
        div_we    = 1'b1;
        div_wdata = n;
        @(negedge clk_osc);
        div_we    = 1'b0;
    endtask

    task automatic write_cko(input logic v);
        @(negedge clk_osc);
        cko_we    = 1'b1;
        cko_wdata = v;
        @(negedge clk_osc);
        cko_we    = 1'b0;
    endtask

    // Pulse one reset, then count edges until ready; checks gating while waiting.
    task automatic restart(input logic [1:0] src, input bit use_por, input int exp, input string req);
        int  k = 0;
        bit  leak = 0;
        @(negedge clk_osc);
        src_sel = src;
        if (use_por) por_n = 1'b0; else rst_n = 1'b0;
        repeat (3) @(negedge clk_osc);
        chk(!ready && !cpu_ce && !per_ce && !clk_out, "R3 outputs low in reset", int'(ready), 0);
        por_n = 1'b1;
        rst_n = 1'b1;
        while (!ready && k < 3000) begin
            @(negedge clk_osc);
            k++;
            if (!ready && (cpu_ce || per_ce || clk_out)) leak = 1;
        end
        chk(k == exp, req, k, exp);
        chk(!leak, "R3 no enable before ready", int'(leak), 0);
        chk(cpu_ce && per_ce, "R10/R7 first enables on ready cycle", int'(cpu_ce), 1);
    endtask

    task automatic t_holdoff();
        restart(2'b00, 1'b0, 224, "R2 holdoff RC");
        restart(2'b01, 1'b0, 224, "R2 holdoff watchdog osc");
        restart(2'b10, 1'b0, 992, "R1 holdoff crystal");
        restart(2'b11, 1'b0, 992, "R1 holdoff crystal high");
    endtask

    task automatic t_div_zero();
        int ce_n = 0, per_n = 0;
        restart(2'b00, 1'b0, 224, "R2 holdoff before ratio 0");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_osc);
            if (cpu_ce) ce_n++;
            if (per_ce) per_n++;
        end
        chk(ce_n == 20, "R4 ratio 0 every cycle", ce_n, 20);
        chk(per_n == 10, "R7 peripheral half rate at ratio 0", per_n, 10);
        chk(ready, "R3 ready stays high", int'(ready), 1);
    endtask

    task automatic t_period(input logic [7:0] n);
        int k;
        write_div(n);
        wait_ce();
        measure_ce(k);
        chk(k == 2 * int'(n), $sformatf("R5 period for N=%0d", n), k, 2 * int'(n));
    endtask

    task automatic t_midchange();
        int k;
        write_div(8'd4);
        wait_ce();
        wait_ce();
        k = 0;
        do begin
            @(negedge clk_osc);
            k++;
            if (k == 3) begin div_we = 1'b1; div_wdata = 8'd2; end
            if (k == 4) div_we = 1'b0;
        end while (!cpu_ce && k < 3000);
        chk(k == 8, "R6 current period completes", k, 8);
        measure_ce(k);
        chk(k == 4, "R6 new ratio next period", k, 4);
    endtask

    task automatic t_per(input logic [7:0] n);
        int k = 0, g = 0;
        write_div(n);
        wait_ce();
        do begin @(negedge clk_osc); g++; end while (!per_ce && g < 3000);
        do begin @(negedge clk_osc); k++; end while (!per_ce && k < 3000);
        chk(k == 4 * int'(n), $sformatf("R7 peripheral period N=%0d", n), k, 4 * int'(n));
    endtask

    task automatic t_clkout();
        int k = 0, g = 0, hi = 0;
        bit prev;
        write_div(8'd2);
        write_cko(1'b1);
        wait_ce();
        prev = clk_out;
        do begin @(negedge clk_osc); g++; end while (!(clk_out && !prev) && g < 3000 && ((prev = clk_out) || 1));
        prev = clk_out;
        do begin
            @(negedge clk_osc);
            k++;
            if (clk_out && !prev) break;
            prev = clk_out;
        end while (k < 3000);
        chk(k == 8, "R8 clk_out period 4N", k, 8);
        write_cko(1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_osc);
            if (clk_out) hi++;
        end
        chk(hi == 0, "R8 clk_out low when disabled", hi, 0);
    endtask

    task automatic t_por_only();
        int rises = 0;
        bit prev;
        write_cko(1'b1);
        restart(2'b00, 1'b0, 224, "R2 holdoff before retention");
        prev = clk_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_osc);
            if (clk_out && !prev) rises++;
            prev = clk_out;
        end
        chk(rises > 0, "R9 enable kept over rst_n", rises, 1);
        restart(2'b00, 1'b1, 224, "R2 holdoff after power-on");
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_osc);
            if (clk_out) rises++;
        end
        chk(rises == 0, "R9 enable cleared by por_n", rises, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; src_sel = 2'b00;
        div_we = 1'b0; div_wdata = '0; cko_we = 1'b0; cko_wdata = 1'b0;
        repeat (3) @(negedge clk_osc);
        chk(!ready && !cpu_ce && !per_ce && !clk_out, "R3 reset state", int'(ready), 0);
        por_n = 1'b1; rst_n = 1'b1;
        t_holdoff();
        t_div_zero();
        t_period(8'd1);
        t_period(8'd3);
        t_period(8'd255);
        t_midchange();
        t_per(8'd3);
        t_clkout();
        t_por_only();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule